// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a supervision counter for a processor subsystem. Once armed, it counts qualified clock ticks down from a programmed period. If software does not service it before the count runs out, it raises a one-cycle reset request. The request goes only to the on-chip reset logic and never drives an external pin.

Servicing is deliberately strict. Software must write the byte AAh to the service port and then the byte 55h. Any other order, or any foreign byte in between, does not count as a service. The enable control is active low. Once the watchdog has been armed, it stays armed until the next system reset, so runaway code cannot switch it off.

The tick input is a plain count enable that comes from a prescaler outside the block. The period input is sampled each time the counter reloads.

Top module: `wdg_keyed_watchdog`

## Requirements
- R1: After reset the reset request output is low and the watchdog is disarmed, so it does not count.
- R2: While the enable input has stayed high (logic 1) since reset, no reset request is ever raised, whatever the ticks and service writes.
- R3: Once armed by driving the enable input low, a reset request is raised on the P-th cycle with the tick input high after arming or after the last reload. P is the period input, and any value below 2 is treated as 2. Cycles with the tick input low are not counted.
- R4: The reset request is high for exactly one cycle. The counter then reloads, and the next request follows after another P ticks when no service happens.
- R5: A service is a write of AAh followed by a write of 55h. Cycles without a write may fall between the two. The counter reloads with P on the cycle after the 55h write. A tick in that reload cycle is not counted and cannot raise a request.
- R6: A write of 55h that is not preceded by a pending AAh does not reload the counter. The count left over is unchanged.
- R7: A write of any byte other than AAh or 55h cancels a pending AAh. A repeated AAh keeps the key pending.
- R8: Once armed, raising the enable input back to 1 has no effect. Requests keep coming on schedule until the next system reset.
- R9: If the 55h write lands in the cycle of the expiring tick, the reset request is still raised. The service reload follows on the next cycle, and a full period of P ticks is counted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick_i | input | 1 | Count enable from the external prescaler |
| wr_en_i | input | 1 | Write strobe for the service port |
| wr_data_i | input | DATA_W | Byte written to the service port |
| en_n_i | input | 1 | Active-low watchdog enable (sticky once low) |
| period_i | input | CNT_W | Timeout period in ticks |
| rst_req_o | output | 1 | One-cycle internal reset request |

## Verification
Two of the block's functions can fall in the same cycle: the service reload and the expiring tick. The bench brings them together in two ways.

In the first, a tick is placed in the reload cycle when only one count remains. The service must win, so no request is raised, and a full period follows.

In the second, the closing 55h is written together with the tick that empties the counter. The request must still appear, and the reload on the following cycle must restart a full period.

Both cases are judged by counting the ticks the bench applies up to the next observed request and comparing that count with the period computed in the bench.

// File: rtl/wdg_pkg.sv
// Package: shared types for the keyed watchdog.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package wdg_pkg;

    // Progress of the two-byte service key.
    typedef enum logic {
        KEY_IDLE   = 1'b0,
        KEY_PRIMED = 1'b1
    } key_state_e;

endpackage

// File: rtl/wdg_key_match.sv
// Module: wdg_key_match
// Watches writes to the service port and emits a one-cycle refresh pulse,
// registered, in the cycle after a KEY_SECOND write that follows a pending
// KEY_FIRST. Any other byte drops the pending state.
// Assumes: a synchronous active-low reset, and one write per cycle at most.
module wdg_key_match
    import wdg_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              refresh_o
);

    key_state_e state_q;
    key_state_e state_d;
    logic       hit_first;
    logic       hit_second;
    logic       refresh_d;

    // Decode the written byte against both keys.
    always_comb begin
        hit_first  = wr_en_i && (wr_data_i == KEY_FIRST);
        hit_second = wr_en_i && (wr_data_i == KEY_SECOND);
    end

    // Next key state and refresh decision; idle cycles keep the state.
    always_comb begin
        state_d   = state_q;
        refresh_d = 1'b0;
        if (wr_en_i) begin
            if (hit_first) begin
                state_d = KEY_PRIMED;
            end else if (hit_second && (state_q == KEY_PRIMED)) begin
                state_d   = KEY_IDLE;
                refresh_d = 1'b1;
            end else begin
                state_d = KEY_IDLE;
            end
        end
    end

    // Register the key state and the refresh pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= KEY_IDLE;
            refresh_o <= 1'b0;
        end else begin
            state_q   <= state_d;
            refresh_o <= refresh_d;
        end
    end

    // A refresh always follows a write of the second key byte.
    p_refresh_after_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |-> ($past(wr_en_i) && ($past(wr_data_i) == KEY_SECOND)));

    // Two second-key writes in a row never give two refreshes.
    p_refresh_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_o |=> !refresh_o);

    // A foreign byte leaves the matcher idle.
    p_foreign_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !hit_first && !hit_second) |=> (state_q == KEY_IDLE));

endmodule

// File: rtl/wdg_arm_latch.sv
// Module: wdg_arm_latch
// Holds the sticky armed flag. A low level on the active-low enable arms the
// watchdog, and only a system reset disarms it again.
// Assumes: en_n_i is synchronous to clk.
module wdg_arm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en_n_i,
    output logic armed_o
);

    // Set on a low enable; never cleared except by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_o <= 1'b0;
        end else if (!en_n_i) begin
            armed_o <= 1'b1;
        end
    end

    // Once armed, the flag stays up until reset.
    p_arm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o);

    // The flag only rises after a low enable.
    p_arm_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(!en_n_i));

endmodule

// File: rtl/wdg_countdown.sv
// Module: wdg_countdown
// Tick-qualified down counter. It loads the period (clamped to MIN_PERIOD)
// while disarmed, on a refresh, and after an expiry. On the tick that finds
// one count left it raises a one-cycle expire pulse. A refresh takes priority
// over a tick in the same cycle.
// Assumes: refresh_i is a registered pulse from the key matcher.
module wdg_countdown #(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             tick_i,
    input  logic             refresh_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] MIN_LOAD = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             at_end;

    // Clamp the period and detect the last remaining count.
    always_comb begin
        load_val = (period_i < MIN_LOAD) ? MIN_LOAD : period_i;
        at_end   = (cnt_q <= ONE);
    end

    // Reload, decrement or expire once per qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (!armed_i || refresh_i) begin
                cnt_q <= load_val;
            end else if (tick_i) begin
                if (at_end) begin
                    cnt_q    <= load_val;
                    expire_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    // An armed counter always holds a live count.
    p_cnt_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_i |-> (cnt_q != '0));

    // The expire pulse lasts a single cycle.
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

    // A refresh cycle never produces an expiry.
    p_refresh_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> !expire_o);

    // No expiry follows a disarmed cycle.
    p_no_fire_disarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> !expire_o);

    // Without a tick the count does not move unless it is reloaded.
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !tick_i && !refresh_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdg_keyed_watchdog.sv
// Module: wdg_keyed_watchdog (top)
// A watchdog with a sticky active-low enable and a two-byte keyed service
// port. It joins the key matcher, the arm latch and the countdown, and emits
// an internal one-cycle reset request.
// Assumes: all inputs are synchronous to clk; tick_i comes from a prescaler
// outside the block.
module wdg_keyed_watchdog #(
    parameter int                CNT_W      = 16,
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
    parameter int                MIN_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              en_n_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic              rst_req_o
);

    logic armed;
    logic refresh;
    logic expire;

    // Service key detection.
    wdg_key_match #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) key_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .refresh_o(refresh)
    );

    // Sticky enable.
    wdg_arm_latch arm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_n_i (en_n_i),
        .armed_o(armed)
    );

    // Period countdown.
    wdg_countdown #(
        .CNT_W     (CNT_W),
        .MIN_PERIOD(MIN_PERIOD)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .tick_i   (tick_i),
        .refresh_i(refresh),
        .period_i (period_i),
        .expire_o (expire)
    );

    // Drive the internal reset request.
    always_comb begin
        rst_req_o = expire;
    end

    // A request is only ever seen while the watchdog is armed.
    p_req_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> armed);

    // The request at the port is a single-cycle pulse.
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

endmodule

// File: tb/wdg_keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module wdg_keyed_watchdog_tb_top;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic          en_n;
    logic [CW-1:0] period;
    logic          rst_req;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    wdg_keyed_watchdog #(.CNT_W(CW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .en_n_i   (en_n),
        .period_i (period),
        .rst_req_o(rst_req)
    );

    // Hang guard: counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int p);
        return (p < 2) ? 2 : p;
    endfunction

    task automatic step(input logic t, input logic w, input logic [7:0] d);
        tick    = t;
        wr_en   = w;
        wr_data = d;
        @(negedge clk);
        tick    = 1'b0;
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        en_n    = 1'b1;
        tick    = 1'b0;
        wr_en   = 1'b0;
        wr_data = 8'h00;
        period  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic arm(input int p);
        period = p[CW-1:0];
        en_n   = 1'b0;
        step(1'b0, 1'b0, 8'h00);
    endtask

    // Ticks applied up to and including the first observed request; -1 if none.
    task automatic measure(input int every, output int ticks);
        ticks = 0;
        for (int i = 0; i < 400; i++) begin
            bit t;
            t = ((i % every) == 0);
            step(t, 1'b0, 8'h00);
            if (t) ticks++;
            if (rst_req) return;
        end
        ticks = -1;
    endtask

    initial begin
        int n;
        int pulses;

        // R1: reset state
        do_reset();
        check(rst_req == 1'b0, "R1 request low after reset", int'(rst_req), 0);

        // R2: never armed, with ticks and service writes
        period = 2;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b1, (i % 5) < 2, ((i % 5) == 0) ? 8'hAA : 8'h55);
            if (rst_req) pulses++;
        end
        check(pulses == 0, "R2 disarmed requests", pulses, 0);
        check(rst_req == 1'b0, "R1 disarmed after reset", int'(rst_req), 0);

        // R3/R4: sweep of periods and tick spacings
        for (int p = 0; p < 8; p++) begin
            for (int ev = 1; ev <= 3; ev++) begin
                do_reset();
                arm(p);
                measure(ev, n);
                check(n == eff(p), "R3 ticks to first request", n, eff(p));
                step(1'b0, 1'b0, 8'h00);
                check(rst_req == 1'b0, "R4 request width", int'(rst_req), 0);
                measure(ev, n);
                check(n == eff(p), "R4 ticks to second request", n, eff(p));
            end
        end

        // R5/R6/R7: service sequences after k ticks
        for (int p = 3; p <= 6; p++) begin
            for (int k = 1; k < p; k++) begin
                for (int s = 0; s < 6; s++) begin
                    bit good;
                    do_reset();
                    arm(p);
                    for (int j = 0; j < k; j++) step(1'b1, 1'b0, 8'h00);
                    good = (s < 4);
                    case (s)
                        0: begin step(1'b0, 1'b1, 8'hAA); step(1'b0, 1'b1, 8'h55); end
                        1: begin step(1'b0, 1'b1, 8'hAA); step(1'b0, 1'b1, 8'h55); end
                        2: begin step(1'b0, 1'b1, 8'hAA); step(1'b0, 1'b0, 8'h00);
                                 step(1'b0, 1'b1, 8'h55); end
                        3: begin step(1'b0, 1'b1, 8'hAA); step(1'b0, 1'b1, 8'hAA);
                                 step(1'b0, 1'b1, 8'h55); end
                        4: begin step(1'b0, 1'b1, 8'h55); end
                        default: begin step(1'b0, 1'b1, 8'hAA); step(1'b0, 1'b1, 8'h12);
                                 step(1'b0, 1'b1, 8'h55); end
                    endcase
                    if (s == 1) begin
                        step(1'b1, 1'b0, 8'h00);
                        check(rst_req == 1'b0, "R5 tick in reload cycle", int'(rst_req), 0);
                    end else begin
                        step(1'b0, 1'b0, 8'h00);
                    end
                    measure(1, n);
                    if (good) begin
                        check(n == p, (s == 3) ? "R7 repeated first key" : "R5 full period after service", n, p);
                    end else begin
                        check(n == p - k, (s == 4) ? "R6 lone second key" : "R7 foreign byte aborts", n, p - k);
                    end
                end
            end
        end

        // R8: enable raised after arming
        for (int p = 2; p <= 5; p++) begin
            do_reset();
            arm(p);
            en_n = 1'b1;
            step(1'b0, 1'b0, 8'h00);
            measure(2, n);
            check(n == p, "R8 sticky enable", n, p);
        end

        // R9: closing key on the expiring tick
        for (int p = 2; p <= 6; p++) begin
            do_reset();
            arm(p);
            for (int j = 0; j < p - 1; j++) step(1'b1, 1'b0, 8'h00);
            step(1'b0, 1'b1, 8'hAA);
            step(1'b1, 1'b1, 8'h55);
            check(rst_req == 1'b1, "R9 request despite late key", int'(rst_req), 1);
            step(1'b0, 1'b0, 8'h00);
            check(rst_req == 1'b0, "R9 single pulse", int'(rst_req), 0);
            measure(1, n);
            check(n == p, "R9 full period after late key", n, p);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule